// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device end of a three-wire serial register port: an active-low select, a serial clock and one shared data line. The host uses it to reach four byte-wide registers. These are a free scratch register, a read-only identification byte, a display-resolution register and a power/ownership register. The block drives a 3-bit resolution select and an active/standby control towards the panel logic.

All three serial inputs are resynchronised into the block's own clock and their edges are found there, so the serial clock must be several times slower than `clk`. A write frame carries a command unit and then a data unit. A read frame carries seven command bits and one idle turnaround clock, after which the slave drives eight bits onto the shared line. The line is modelled as separate input, output and output-enable ports. While the ownership bit is clear, the resolution and standby controls come from strap pins. Once it is set, they come from the registers.

Top module: `spi3_regslave`

## Requirements
- R1: A write frame sends bits MSB first on rising serial clock edges. Edges 1 to 6 carry the register address, edge 7 carries 0 (write) and edge 8 is a pad bit that is ignored. Edges 9 to 16 carry the data byte, which takes effect once the 16th edge has been seen.
- R2: A read frame carries the address on edges 1 to 6 and a 1 on edge 7. During the 8th clock the slave keeps the line released (output enable low).
- R3: In a read, the slave drives the register byte MSB first. The output changes after the falling edges of clocks 8 to 15, so the host samples each bit at rising edges 9 to 16. The slave releases the line after the falling edge of clock 16.
- R4: Address 0 is an 8-bit scratch register whose every written value reads back unchanged (0x55 and 0xAA included).
- R5: Address 1 reads as {CHIP_CODE, VERSION}, which is 0xA3 by default, and writes to it are ignored.
- R6: Address 3 holds bit 7 = software ownership and bit 0 = power (1 active, 0 standby). Its other bits read 0.
- R7: While bit 7 of address 3 is 1, the resolution output equals bits 2:0 of address 2 and the active output equals bit 0 of address 3. Bits 7:3 of address 2 read 0.
- R8: While bit 7 of address 3 is 0, the resolution output and bits 2:0 of address 2 read back the strap resolution input. The active output follows the strap active input.
- R9: Raising chip select releases the line and abandons the frame. A write frame cut short before its 16th edge changes nothing.
- R10: Reset (rst_n low) sets address 0 to 0x00, the stored resolution to RES_DEFAULT (7) and address 3 to 0x00.
- R11: Addresses 4 to 63 read 0x00, and writes to them alter no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Shared data line as seen at the pin |
| sdio_out | output | 1 | Data the slave puts on the shared line |
| sdio_oe | output | 1 | High while the slave drives the shared line |
| strap_res | input | 3 | Strapped resolution code |
| strap_awake | input | 1 | Strapped active (1) / standby (0) level |
| res_sel | output | 3 | Resolution select to the panel logic |
| awake | output | 1 | 1 = active, 0 = standby |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a 6-bit address, 8-bit data, identification byte 0xA3 and default resolution 7. The serial clock half period is 8 block clocks, which leaves margin for the synchroniser and edge-detect delay before each host sample. The defaults make the identification and reset values known constants. The 6-bit address also lets the bench aim writes at addresses 4 and 5, whose low bits alias registers 0 and 1, to show that no aliasing takes place.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
   localparam int ADDR_W     = 6;
   localparam int DATA_W     = 8;
   localparam int RES_W      = 3;
   localparam int CTL_SW_BIT = 7;
   localparam int CTL_PM_BIT = 0;

   typedef enum logic [1:0] {
      REG_SCRATCH = 2'd0,
      REG_IDENT   = 2'd1,
      REG_RES     = 2'd2,
      REG_PWR     = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial assert (STAGES >= 2) else $error("spi3_sync: STAGES must be at least 2");

   logic [WIDTH-1:0] st [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= RST_VAL;
               else        st[i] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= RST_VAL;
               else        st[i] <= st[i-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              csn_s,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wdata,
   output logic              rd_frame,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int CMD_BITS   = ADDR_W + 1;
   localparam int DATA_START = CMD_BITS + 1;
   localparam int LAST       = DATA_START + DATA_W;
   localparam int CNT_W      = $clog2(LAST + 2);

   initial assert (DATA_W >= ADDR_W) else $error("spi3_frame: DATA_W must cover ADDR_W");

   logic              sclk_q;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] tx;
   logic              rise, fall;

   assign rise = sclk_s & ~sclk_q;
   assign fall = ~sclk_s & sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
         tx       <= '0;
         addr     <= '0;
         wr_stb   <= 1'b0;
         wdata    <= '0;
         rd_frame <= 1'b0;
         sdo      <= 1'b0;
         sdo_oe   <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         wr_stb <= 1'b0;
         if (csn_s) begin
            cnt      <= '0;
            rd_frame <= 1'b0;
            sdo_oe   <= 1'b0;
         end else begin
            if (rise) begin
               sh <= {sh[DATA_W-2:0], sdi_s};
               if (cnt != CNT_W'(LAST + 1)) cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(CMD_BITS - 1)) begin
                  addr     <= sh[ADDR_W-1:0];
                  rd_frame <= sdi_s;
               end
               if (cnt == CNT_W'(LAST - 1) && !rd_frame) begin
                  wr_stb <= 1'b1;
                  wdata  <= {sh[DATA_W-2:0], sdi_s};
               end
            end
            if (fall && rd_frame) begin
               if (cnt == CNT_W'(DATA_START)) begin
                  sdo_oe <= 1'b1;
                  sdo    <= rdata[DATA_W-1];
                  tx     <= {rdata[DATA_W-2:0], 1'b0};
               end else if (cnt > CNT_W'(DATA_START) && cnt < CNT_W'(LAST)) begin
                  sdo <= tx[DATA_W-1];
                  tx  <= {tx[DATA_W-2:0], 1'b0};
               end else if (cnt == CNT_W'(LAST)) begin
                  sdo_oe <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi3_regs.sv
module spi3_regs
   import spi3_pkg::*;
#(
   parameter int              ADDR_W      = 6,
   parameter int              DATA_W      = 8,
   parameter int              RES_W       = 3,
   parameter logic [3:0]      CHIP_CODE   = 4'hA,
   parameter logic [3:0]      VERSION     = 4'h3,
   parameter logic [RES_W-1:0] RES_DEFAULT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RES_W-1:0]  strap_res,
   input  logic              strap_awake,
   output logic [DATA_W-1:0] rdata,
   output logic [RES_W-1:0]  res_sel,
   output logic              awake,
   output logic              sw_ctl
);
   localparam logic [DATA_W-1:0] ID_VAL = DATA_W'({CHIP_CODE, VERSION});

   initial assert (DATA_W == 8) else $error("spi3_regs: DATA_W must be 8");
   initial assert (RES_W < DATA_W) else $error("spi3_regs: RES_W too wide");

   logic              hit;
   logic [DATA_W-1:0] scratch_q;
   logic [RES_W-1:0]  res_q;
   logic              pm_q;
   reg_sel_e          sel;

   assign hit = (addr[ADDR_W-1:2] == '0);
   assign sel = reg_sel_e'(addr[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch_q <= '0;
         res_q     <= RES_DEFAULT;
         sw_ctl    <= 1'b0;
         pm_q      <= 1'b0;
      end else if (wr_stb && hit) begin
         case (sel)
            REG_SCRATCH: scratch_q <= wdata;
            REG_RES:     res_q     <= wdata[RES_W-1:0];
            REG_PWR: begin
               sw_ctl <= wdata[CTL_SW_BIT];
               pm_q   <= wdata[CTL_PM_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         case (sel)
            REG_SCRATCH: rdata = scratch_q;
            REG_IDENT:   rdata = ID_VAL;
            REG_RES:     rdata[RES_W-1:0] = sw_ctl ? res_q : strap_res;
            REG_PWR: begin
               rdata[CTL_SW_BIT] = sw_ctl;
               rdata[CTL_PM_BIT] = pm_q;
            end
            default: rdata = '0;
         endcase
      end
   end

   assign res_sel = sw_ctl ? res_q : strap_res;
   assign awake   = sw_ctl ? pm_q  : strap_awake;
endmodule

// File: rtl/spi3_regslave.sv
module spi3_regslave
   import spi3_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [3:0]       CHIP_CODE   = 4'hA,
   parameter logic [3:0]       VERSION     = 4'h3,
   parameter logic [RES_W-1:0] RES_DEFAULT = 3'd7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_csn,
   input  logic             ser_clk,
   input  logic             sdio_in,
   output logic             sdio_out,
   output logic             sdio_oe,
   input  logic [RES_W-1:0] strap_res,
   input  logic             strap_awake,
   output logic [RES_W-1:0] res_sel,
   output logic             awake
);
   logic              csn_s, sclk_s, sdi_s;
   logic [ADDR_W-1:0] acc_addr;
   logic              wr_stb, rd_frame, sw_ctl;
   logic [DATA_W-1:0] wdata, rdata;

   spi3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_csn, ser_clk, sdio_in}),
      .q     ({csn_s, sclk_s, sdi_s})
   );

   spi3_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .csn_s    (csn_s),
      .sdi_s    (sdi_s),
      .rdata    (rdata),
      .addr     (acc_addr),
      .wr_stb   (wr_stb),
      .wdata    (wdata),
      .rd_frame (rd_frame),
      .sdo      (sdio_out),
      .sdo_oe   (sdio_oe)
   );

   spi3_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W),
      .CHIP_CODE(CHIP_CODE), .VERSION(VERSION), .RES_DEFAULT(RES_DEFAULT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (acc_addr),
      .wr_stb      (wr_stb),
      .wdata       (wdata),
      .strap_res   (strap_res),
      .strap_awake (strap_awake),
      .rdata       (rdata),
      .res_sel     (res_sel),
      .awake       (awake),
      .sw_ctl      (sw_ctl)
   );
endmodule

// File: rtl/spi3_regslave_chk.sv
module spi3_regslave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       csn_s,
   input logic       sdio_oe,
   input logic       rd_frame,
   input logic       wr_stb,
   input logic [5:0] wr_addr,
   input logic [7:0] wdata,
   input logic       sw_ctl
);
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !sdio_oe); // R9

   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> rd_frame); // R3

   AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !rd_frame); // R1

   AST_OWNER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == 6'd3) |=> (sw_ctl == $past(wdata[7]))); // R6

   AST_HIGH_ADDR_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr[5:2] != 4'd0) |=> $stable(sw_ctl)); // R11
endmodule

bind spi3_regslave spi3_regslave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .csn_s    (csn_s),
   .sdio_oe  (sdio_oe),
   .rd_frame (rd_frame),
   .wr_stb   (wr_stb),
   .wr_addr  (acc_addr),
   .wdata    (wdata),
   .sw_ctl   (sw_ctl)
);

// File: tb/sim_spi3_regslave.sv
`timescale 1ns/1ps
module sim_spi3_regslave;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_csn = 1'b1;
   logic       ser_clk = 1'b0;
   logic       sdio_in = 1'b0;
   logic       sdio_out, sdio_oe;
   logic [2:0] strap_res = 3'd5;
   logic       strap_awake = 1'b1;
   logic [2:0] res_sel;
   logic       awake;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] got_byte;
   event       rd_done;

   always #2.5 clk = ~clk;

   spi3_regslave u0 (
      .clk(clk), .rst_n(rst_n), .ser_csn(ser_csn), .ser_clk(ser_clk),
      .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
      .strap_res(strap_res), .strap_awake(strap_awake),
      .res_sel(res_sel), .awake(awake)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic bit_cycle(input logic b, output logic r, output logic oe);
      ser_clk = 1'b0;
      sdio_in = b;
      #40;
      r  = sdio_out;
      oe = sdio_oe;
      ser_clk = 1'b1;
      #40;
   endtask

   task automatic frame_end();
      ser_clk = 1'b0;
      #40;
      ser_csn = 1'b1;
      #80;
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      logic r, oe;
      ser_csn = 1'b0;
      #40;
      for (int i = 5; i >= 0; i--) bit_cycle(a[i], r, oe);
      bit_cycle(1'b0, r, oe);
      bit_cycle(1'b0, r, oe);
      for (int i = 7; i >= 0; i--) bit_cycle(d[i], r, oe);
      frame_end();
   endtask

   // driver: pushes the expected byte, monitor compares when the frame ends
   task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
      logic r, oe;
      logic all_oe;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      ser_csn = 1'b0;
      #40;
      for (int i = 5; i >= 0; i--) bit_cycle(a[i], r, oe);
      bit_cycle(1'b1, r, oe);
      bit_cycle(1'b0, r, oe);
      check("R2 line released in turnaround", {7'd0, oe}, 8'd0);
      all_oe = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b0, r, oe);
         got_byte[i] = r;
         all_oe = all_oe & oe;
      end
      check("R3 driven for all data bits", {7'd0, all_oe}, 8'd1);
      frame_end();
      check("R3 released after frame", {7'd0, sdio_oe}, 8'd0);
      -> rd_done;
      #1;
   endtask

   initial begin
      forever begin
         @(rd_done);
         check(tag_q.pop_front(), got_byte, exp_q.pop_front());
      end
   end

   initial begin
      #500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic r, oe;
      #100;
      rst_n = 1'b1;
      #50;
      // reset state, hardware ownership
      check("R10 oe after reset", {7'd0, sdio_oe}, 8'd0);
      check("R8 res_sel from strap", {5'd0, res_sel}, 8'd5);
      check("R8 awake from strap", {7'd0, awake}, 8'd1);
      rd(6'd0, 8'h00, "R10 scratch reset");
      rd(6'd1, 8'hA3, "R5 identification");
      rd(6'd2, 8'h05, "R8 resolution reads strap");
      rd(6'd3, 8'h00, "R10 power reg reset");

      // scratch register
      wr(6'd0, 8'h55);
      rd(6'd0, 8'h55, "R4 scratch 0x55");
      wr(6'd0, 8'hAA);
      rd(6'd0, 8'hAA, "R1 R4 scratch 0xAA");

      // identification is read-only
      wr(6'd1, 8'h00);
      rd(6'd1, 8'hA3, "R5 ident write ignored");

      // software ownership, standby
      wr(6'd3, 8'h80);
      check("R10 R7 res_sel default", {5'd0, res_sel}, 8'd7);
      check("R7 awake from reg", {7'd0, awake}, 8'd0);
      rd(6'd3, 8'h80, "R6 power reg owner");
      rd(6'd2, 8'h07, "R7 resolution reg default");

      wr(6'd2, 8'hFE);
      check("R7 res_sel from reg", {5'd0, res_sel}, 8'd6);
      rd(6'd2, 8'h06, "R7 upper bits read 0");

      wr(6'd3, 8'hFF);
      rd(6'd3, 8'h81, "R6 unused bits read 0");
      check("R7 awake active", {7'd0, awake}, 8'd1);

      // back to hardware ownership
      wr(6'd3, 8'h01);
      check("R8 res_sel back to strap", {5'd0, res_sel}, 8'd5);
      strap_awake = 1'b0;
      strap_res = 3'd3;
      #20;
      check("R8 awake follows strap", {7'd0, awake}, 8'd0);
      check("R8 res_sel follows strap", {5'd0, res_sel}, 8'd3);
      rd(6'd2, 8'h03, "R8 resolution reads new strap");
      rd(6'd3, 8'h01, "R6 power bit kept");

      // out-of-range addresses
      wr(6'd5, 8'h12);
      rd(6'd5, 8'h00, "R11 high address reads 0");
      wr(6'd4, 8'h33);
      rd(6'd0, 8'hAA, "R11 no alias to scratch");
      wr(6'd7, 8'h80);
      check("R11 no alias to power reg", {5'd0, res_sel}, 8'd3);

      // aborted write frame
      ser_csn = 1'b0;
      #40;
      for (int i = 5; i >= 0; i--) bit_cycle(1'b0, r, oe);
      bit_cycle(1'b0, r, oe);
      bit_cycle(1'b0, r, oe);
      for (int i = 0; i < 4; i++) bit_cycle(1'b1, r, oe);
      frame_end();
      check("R9 oe low after abort", {7'd0, sdio_oe}, 8'd0);
      rd(6'd0, 8'hAA, "R9 aborted write ignored");

      // reset in mid-run
      wr(6'd0, 8'h5A);
      wr(6'd3, 8'h81);
      rst_n = 1'b0;
      #50;
      rst_n = 1'b1;
      #50;
      rd(6'd0, 8'h00, "R10 scratch cleared");
      rd(6'd3, 8'h00, "R10 power reg cleared");
      check("R10 res_sel strap after reset", {5'd0, res_sel}, 8'd3);

      #100;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule